// File: doc/BRIEF.md
# Edge-Detecting General-Purpose I/O Bank

This block is one bank of general-purpose pins with a small word-addressed register file. Software chooses a direction for each pin, drives output pins high or low with atomic set and clear registers, reads the level on every pin whatever its direction, and picks which pins report rising edges, falling edges or both. A detected edge latches into a sticky status bit. Software clears that bit by writing a 1 to it.

The pad levels are brought into the bank's clock domain by a synchronizer chain before they are used. Edges are found by comparing the synchronized level with its value one clock earlier. The output data and both edge-enable masks are changed only through their set and clear registers, so software never needs a read-modify-write. Read data is registered, and the pad loopback adds latency, so a read issued just after an output change can still return the old level.

Top module: `gpio_edge_bank`

## Requirements
- R1: After reset every pin is an input (direction word all ones, `pin_oe` all zero), `pin_out` is zero, both edge-enable masks are zero and the status word is zero.
- R2: The direction word at byte offset 0x00 is read/write. A bit of 1 makes the pin an input (`pin_oe` bit low). A bit of 0 makes it an output (`pin_oe` bit high). The direction changes only when this offset is written.
- R3: A write to offset 0x08 raises each output bit written as 1, and a write to offset 0x0C lowers each output bit written as 1. Bits written as 0 keep their value. `pin_out` shows the new value from the clock edge that accepts the write. Reads of 0x04, 0x08 and 0x0C return the output word.
- R4: Writes to 0x04 (output word) and 0x10 (input word) are ignored. So are writes to unmapped offsets (0x28 and above) and to addresses that are not 4-byte aligned. Reads of unmapped or misaligned addresses return 0.
- R5: A read of offset 0x10 returns the synchronized pad level of every pin, outputs included. A pad change is not visible to a read issued at the next falling clock edge. It is visible to a read issued once the level has had three clocks to settle.
- R6: Writing 1s to 0x14 or 0x1C enables rising-edge or falling-edge detection on those pins. Writing 1s to 0x18 or 0x20 disables it. Zero bits are unchanged. Reads of 0x14 and 0x18 return the rising mask, and reads of 0x1C and 0x20 return the falling mask.
- R7: An edge on a pin whose matching enable is set raises that pin's bit in the status word at 0x24. The bit stays set until a 1 is written to it. An edge whose enable is clear sets nothing. A pin with both enables set reports both directions.
- R8: Edge detection also works on output pins, through the pad loopback.
- R9: If a newly detected edge and a write-one-to-clear of the same status bit take effect on the same clock edge, the bit stays set.
- R10: Read data is registered. It appears on `bus_rdata` one clock after a read request and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bank clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_req | input | 1 | Register access request, one cycle per access |
| bus_we | input | 1 | 1 for write, 0 for read |
| bus_addr | input | 6 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| pin_in | input | 32 | Pad levels, including the loopback from driven pins |
| pin_out | output | 32 | Output level per pin |
| pin_oe | output | 32 | Output enable per pin, high when the pin is an output |

## Verification
The bench targets a write-one-to-clear landing on the same clock edge as a fresh edge on that bit. A design that let the clear win would lose the edge. It reads the input word one cycle after a pad change: a design that skipped the synchronizer would show the new level too early. It also fires edges on output pins through the set and clear registers, where a design that gated detection by direction would stay silent. Random phases mix direction flips, writes to read-only and unmapped offsets, and mask changes. A model tracks every pad transition, so a wrong set/clear polarity, a swapped mask readback or a write leaking into a read-only word shows up as a mismatched read.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

   // Register word indices; the order is the bank's address map.
   localparam int unsigned RI_DIR    = 0;
   localparam int unsigned RI_OUT    = 1;
   localparam int unsigned RI_OSET   = 2;
   localparam int unsigned RI_OCLR   = 3;
   localparam int unsigned RI_IN     = 4;
   localparam int unsigned RI_RSET   = 5;
   localparam int unsigned RI_RCLR   = 6;
   localparam int unsigned RI_FSET   = 7;
   localparam int unsigned RI_FCLR   = 8;
   localparam int unsigned RI_STAT   = 9;
   localparam int unsigned NUM_REGS  = 10;
   localparam int unsigned SEL_W     = 4;

   typedef struct packed {
      logic dir_we;
      logic oset_we;
      logic oclr_we;
      logic rset_we;
      logic rclr_we;
      logic fset_we;
      logic fclr_we;
      logic stat_we;
   } wr_strobes_t;

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
   parameter int unsigned WIDTH  = 32,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] async_in,
   output logic [WIDTH-1:0] sync_out
);

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("gpio_sync: STAGES must be at least 2");
      end
      if (WIDTH < 1) begin : g_bad_width
         $error("gpio_sync: WIDTH must be at least 1");
      end
   endgenerate

   logic [WIDTH-1:0] chain_q [STAGES];

   generate
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain_q[s] <= '0;
               else        chain_q[s] <= async_in;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain_q[s] <= '0;
               else        chain_q[s] <= chain_q[s-1];
            end
         end
      end
   endgenerate

   assign sync_out = chain_q[STAGES-1];

endmodule

// File: rtl/gpio_setclr_reg.sv
module gpio_setclr_reg #(
   parameter int unsigned         WIDTH     = 32,
   parameter logic [WIDTH-1:0]    RESET_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             set_we,
   input  logic             clr_we,
   input  logic [WIDTH-1:0] wmask,
   output logic [WIDTH-1:0] q
);

   generate
      if (WIDTH < 1) begin : g_bad_width
         $error("gpio_setclr_reg: WIDTH must be at least 1");
      end
   endgenerate

   logic [WIDTH-1:0] set_bits;
   logic [WIDTH-1:0] clr_bits;

   assign set_bits = set_we ? wmask : '0;
   assign clr_bits = clr_we ? wmask : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= RESET_VAL;
      else        q <= (q | set_bits) & ~clr_bits;
   end

   // R3 / R6: bits written through the set port are high afterwards
   a_r6_set_bits_high: assert property (@(posedge clk) disable iff (!rst_n)
      (set_we && !clr_we) |=> ((q & $past(wmask)) == $past(wmask)));

   // R3 / R6: bits written through the clear port are low afterwards
   a_r6_clr_bits_low: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_we && !set_we) |=> ((q & $past(wmask)) == '0));

   // R3 / R6: no write leaves the word unchanged
   a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!set_we && !clr_we) |=> $stable(q));

endmodule

// File: rtl/gpio_edge_status.sv
module gpio_edge_status #(
   parameter int unsigned WIDTH = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] level,
   input  logic [WIDTH-1:0] rise_en,
   input  logic [WIDTH-1:0] fall_en,
   input  logic             clr_we,
   input  logic [WIDTH-1:0] clr_mask,
   output logic [WIDTH-1:0] status
);

   logic [WIDTH-1:0] prev_q;
   logic [WIDTH-1:0] hit;
   logic [WIDTH-1:0] drop;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= '0;
      else        prev_q <= level;
   end

   generate
      for (genvar b = 0; b < WIDTH; b++) begin : g_bit
         assign hit[b] = (level[b] & ~prev_q[b] & rise_en[b]) |
                         (~level[b] & prev_q[b] & fall_en[b]);
      end
   endgenerate

   assign drop = clr_we ? clr_mask : '0;

   // A fresh edge outranks a simultaneous clear (R9).
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) status <= '0;
      else        status <= (status & ~drop) | hit;
   end

   // R7: set bits survive any cycle without a clear write
   a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      !clr_we |=> ((status & $past(status)) == $past(status)));

   // R7: a newly raised bit belongs to a pin with some edge enabled
   a_r7_gated: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((status & ~$past(status) & ~($past(rise_en) | $past(fall_en))) == '0));

   // R9: a rising level on an enabled pin during a clear still leaves the bit set
   a_r9_edge_wins: assert property (@(posedge clk) disable iff (!rst_n)
      clr_we |=> ((status & ($past(level) & ~$past(prev_q) & $past(rise_en)))
                  == ($past(level) & ~$past(prev_q) & $past(rise_en))));

endmodule

// File: rtl/gpio_edge_bank.sv
module gpio_edge_bank #(
   parameter int unsigned PINS        = 32,
   parameter int unsigned DATA_W      = 32,
   parameter int unsigned ADDR_W      = 6,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_req,
   input  logic              bus_we,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic [PINS-1:0]   pin_in,
   output logic [PINS-1:0]   pin_out,
   output logic [PINS-1:0]   pin_oe
);

   import gpio_bank_pkg::*;

   localparam int unsigned IDX_W = ADDR_W - 2;

   generate
      if (PINS < 1 || PINS > DATA_W) begin : g_bad_pins
         $error("gpio_edge_bank: PINS must be 1..DATA_W");
      end
      if (ADDR_W < 6) begin : g_bad_addr
         $error("gpio_edge_bank: ADDR_W too small for the register map");
      end
   endgenerate

   // ---------------- address decode ----------------
   logic [IDX_W-1:0]  idx;
   logic              hit_map;
   logic [SEL_W-1:0]  sel;
   logic [NUM_REGS-1:0] wr_onehot;
   wr_strobes_t       wr;

   assign idx     = bus_addr[ADDR_W-1:2];
   assign hit_map = (bus_addr[1:0] == 2'b00) && (idx < IDX_W'(NUM_REGS));
   assign sel     = hit_map ? idx[SEL_W-1:0] : '1;

   generate
      for (genvar r = 0; r < NUM_REGS; r++) begin : g_wstb
         assign wr_onehot[r] = bus_req && bus_we && hit_map && (idx == IDX_W'(r));
      end
   endgenerate

   assign wr.dir_we  = wr_onehot[RI_DIR];
   assign wr.oset_we = wr_onehot[RI_OSET];
   assign wr.oclr_we = wr_onehot[RI_OCLR];
   assign wr.rset_we = wr_onehot[RI_RSET];
   assign wr.rclr_we = wr_onehot[RI_RCLR];
   assign wr.fset_we = wr_onehot[RI_FSET];
   assign wr.fclr_we = wr_onehot[RI_FCLR];
   assign wr.stat_we = wr_onehot[RI_STAT];

   logic [PINS-1:0] wmask;
   assign wmask = bus_wdata[PINS-1:0];

   // ---------------- direction ----------------
   logic [PINS-1:0] dir_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         dir_q <= '1;
      else if (wr.dir_we) dir_q <= wmask;
   end

   // ---------------- set/clear words ----------------
   logic [PINS-1:0] out_q;
   logic [PINS-1:0] rise_q;
   logic [PINS-1:0] fall_q;

   gpio_setclr_reg #(.WIDTH(PINS), .RESET_VAL('0)) u_out (
      .clk(clk), .rst_n(rst_n), .set_we(wr.oset_we), .clr_we(wr.oclr_we),
      .wmask(wmask), .q(out_q));

   gpio_setclr_reg #(.WIDTH(PINS), .RESET_VAL('0)) u_rise (
      .clk(clk), .rst_n(rst_n), .set_we(wr.rset_we), .clr_we(wr.rclr_we),
      .wmask(wmask), .q(rise_q));

   gpio_setclr_reg #(.WIDTH(PINS), .RESET_VAL('0)) u_fall (
      .clk(clk), .rst_n(rst_n), .set_we(wr.fset_we), .clr_we(wr.fclr_we),
      .wmask(wmask), .q(fall_q));

   // ---------------- input path ----------------
   logic [PINS-1:0] level_s;
   logic [PINS-1:0] stat_q;

   gpio_sync #(.WIDTH(PINS), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .async_in(pin_in), .sync_out(level_s));

   gpio_edge_status #(.WIDTH(PINS)) u_edge (
      .clk(clk), .rst_n(rst_n), .level(level_s), .rise_en(rise_q),
      .fall_en(fall_q), .clr_we(wr.stat_we), .clr_mask(wmask), .status(stat_q));

   // ---------------- read path ----------------
   function automatic logic [DATA_W-1:0] widen(input logic [PINS-1:0] v);
      logic [DATA_W-1:0] w;
      w = '0;
      w[PINS-1:0] = v;
      return w;
   endfunction

   logic [DATA_W-1:0] rd_mux;

   always_comb begin
      case (sel)
         SEL_W'(RI_DIR):  rd_mux = widen(dir_q);
         SEL_W'(RI_OUT),
         SEL_W'(RI_OSET),
         SEL_W'(RI_OCLR): rd_mux = widen(out_q);
         SEL_W'(RI_IN):   rd_mux = widen(level_s);
         SEL_W'(RI_RSET),
         SEL_W'(RI_RCLR): rd_mux = widen(rise_q);
         SEL_W'(RI_FSET),
         SEL_W'(RI_FCLR): rd_mux = widen(fall_q);
         SEL_W'(RI_STAT): rd_mux = widen(stat_q);
         default:         rd_mux = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 bus_rdata <= '0;
      else if (bus_req && !bus_we) bus_rdata <= rd_mux;
   end

   assign pin_out = out_q;
   assign pin_oe  = ~dir_q;

   // R2: direction only moves on a write to its own offset
   a_r2_dir_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_req && bus_we && bus_addr == ADDR_W'(0)) |=> $stable(pin_oe));

   // R4: writes other than to the set/clear data offsets leave pin_out alone
   a_r4_out_untouched: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_req && bus_we && (bus_addr == ADDR_W'(8) || bus_addr == ADDR_W'(12)))
      |=> $stable(pin_out));

   // R10: read data holds while no read is requested
   a_r10_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_req && !bus_we) |=> $stable(bus_rdata));

endmodule

// File: tb/gpio_edge_bank_bench.sv
`timescale 1ns/1ps
module gpio_edge_bank_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_req = 1'b0;
   logic        bus_we = 1'b0;
   logic [5:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [31:0] pin_in;
   logic [31:0] pin_out;
   logic [31:0] pin_oe;
   logic [31:0] ext = '0;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   always #2.5 clk = ~clk;

   // pad model: driven pins loop back, others follow the external level
   assign pin_in = (pin_oe & pin_out) | (~pin_oe & ext);

   gpio_edge_bank u_gpio_edge_bank (
      .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe));

   // model state
   logic [31:0] m_dir, m_out, m_rise, m_fall, m_st, m_pad;

   function automatic logic [31:0] exp_reg(input int i);
      case (i)
         0: return m_dir;
         1, 2, 3: return m_out;
         4: return m_pad;
         5, 6: return m_rise;
         7, 8: return m_fall;
         9: return m_st;
         default: return 32'h0;
      endcase
   endfunction

   function automatic string tag_of(input int i);
      case (i)
         0: return "R2";
         1, 2, 3: return "R3";
         4: return "R5";
         5, 6, 7, 8: return "R6";
         9: return "R7";
         default: return "R4";
      endcase
   endfunction

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%08h expected=%08h", tag, act, exp);
      end
   endtask

   task automatic raw_write(input logic [5:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_req = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_req = 1'b0; bus_we = 1'b0;
   endtask

   task automatic bus_read(input logic [5:0] a, output logic [31:0] v);
      @(negedge clk);
      bus_req = 1'b1; bus_we = 1'b0; bus_addr = a;
      @(negedge clk);
      bus_req = 1'b0;
      v = bus_rdata;
   endtask

   // let the pad settle, then account for the one transition it made
   task automatic settle();
      logic [31:0] np;
      repeat (5) @(posedge clk);
      @(negedge clk);
      np = (~m_dir & m_out) | (m_dir & ext);
      m_st |= (np & ~m_pad & m_rise) | (~np & m_pad & m_fall);
      m_pad = np;
   endtask

   task automatic do_write(input int i, input logic [31:0] d);
      raw_write(6'(i * 4), d);
      case (i)
         0: m_dir = d;
         2: m_out |= d;
         3: m_out &= ~d;
         5: m_rise |= d;
         6: m_rise &= ~d;
         7: m_fall |= d;
         8: m_fall &= ~d;
         9: m_st &= ~d;
         default: ;
      endcase
      settle();
   endtask

   task automatic set_ext(input logic [31:0] v);
      @(negedge clk);
      ext = v;
      settle();
   endtask

   task automatic check_all(input string ctx);
      logic [31:0] v;
      for (int i = 0; i < 10; i++) begin
         bus_read(6'(i * 4), v);
         check($sformatf("%s %s reg%0d", tag_of(i), ctx, i), v, exp_reg(i));
      end
      check($sformatf("R3 %s pin_out", ctx), pin_out, m_out);
      check($sformatf("R2 %s pin_oe", ctx), pin_oe, ~m_dir);
   endtask

   initial begin
      logic [31:0] v;
      void'($urandom(32'h5EED_0042));
      m_dir = '1; m_out = '0; m_rise = '0; m_fall = '0; m_st = '0; m_pad = '0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      check("R1 pin_oe after reset", pin_oe, 32'h0);
      check("R1 pin_out after reset", pin_out, 32'h0);
      check_all("R1 reset");

      // R7 both edges on pin 3, plain clear
      do_write(5, 32'h8);
      do_write(7, 32'h8);
      set_ext(32'h8);
      bus_read(6'h24, v); check("R7 rising edge sets status", v, 32'h8);

      // R9 new falling edge lands with the clear
      @(negedge clk); ext = 32'h0; m_pad = 32'h0;
      @(posedge clk); @(posedge clk);
      raw_write(6'h24, 32'h8);
      settle();
      bus_read(6'h24, v); check("R9 edge beats same-cycle clear", v, 32'h8);
      do_write(9, 32'h8);
      bus_read(6'h24, v); check("R7 write-one clears status", v, 32'h0);

      // R7 disabled edge sets nothing
      set_ext(32'h10);
      bus_read(6'h24, v); check("R7 disabled edge ignored", v, 32'h0);

      // R5 synchronizer lag
      @(negedge clk); ext = 32'h90;
      bus_read(6'h10, v); check("R5 input not yet visible", v, 32'h10);
      settle();
      bus_read(6'h10, v); check("R5 input visible after settle", v, 32'h90);

      // R3 / R8 output pin edge
      do_write(0, ~32'h20);
      check("R2 pin 5 driven", pin_oe, 32'h20);
      do_write(5, 32'h20);
      raw_write(6'h08, 32'h20); m_out |= 32'h20;
      check("R3 pin_out after set", pin_out, 32'h20);
      settle();
      bus_read(6'h24, v); check("R8 output pin rising edge", v, 32'h20);
      bus_read(6'h10, v); check("R5 output level readable", v, m_pad);

      // R4 read-only and unmapped
      do_write(1, 32'hFFFF_FFFF);
      do_write(4, 32'hFFFF_FFFF);
      raw_write(6'h28, 32'hFFFF_FFFF); settle();
      raw_write(6'h01, 32'h0); settle();
      bus_read(6'h28, v); check("R4 unmapped read zero", v, 32'h0);
      bus_read(6'h3C, v); check("R4 high unmapped read zero", v, 32'h0);
      bus_read(6'h01, v); check("R4 misaligned read zero", v, 32'h0);
      check_all("R4 after ignored writes");

      // R10 read data holds
      bus_read(6'h00, v);
      repeat (4) @(negedge clk);
      check("R10 rdata holds", bus_rdata, m_dir);

      // random phase
      for (int n = 0; n < 120; n++) begin
         int op;
         logic [31:0] d;
         op = $urandom_range(0, 9);
         d = $urandom;
         if ($urandom_range(0, 3) == 0) d = d & $urandom;
         do_write(op, d);
         set_ext(ext ^ ($urandom & $urandom));
         check_all($sformatf("random step %0d", n));
      end

      if (!done) begin
         done = 1;
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         done = 1;
         checks++; errors++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

endmodule